// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for every received Ethernet frame, whether the frame's destination address is one the station wants. The receive path presents the 48-bit destination address together with a one-cycle valid strobe. Two clock cycles later the block raises its own one-cycle valid, along with an accept bit that stays valid until the next decision.

Several rules can admit an address, and a match on any one is enough:
- The address equals the programmed station address.
- The address is the all-ones broadcast address.
- The address is the fixed flow-control address 01:80:C2:00:00:01.
- The address is multicast and hits the 256-bit hash table.
- Promiscuous mode is on.

The multicast index is computed as follows. A CRC-32 is run over the six address bytes, each byte shifted in least significant bit first. The register starts at all ones, the reflected polynomial 0xEDB88320 is used, and the result is not inverted. The top 8 bits of the result form the index: the upper four bits pick one of sixteen 16-bit hash words, and the lower four bits pick the bit inside that word.

Software programs the block through a simple write port. The port carries a byte offset and 16 bits of data, and is used to load the station address, the hash words and a small receive configuration word.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `decValid` is low and every programmable register is zero: station address 00:00:00:00:00:00, all hash words zero, promiscuous and hash enable off.
- R2: Each cycle with `daValid` high produces exactly one `decValid` pulse, two clock edges later, with `accept` updated in that same cycle. Back-to-back addresses are supported, and no pulse appears without a matching input.
- R3: An address equal to the station address is accepted. Any other unicast address is rejected unless another rule admits it. The station address is written at three offsets: 0x00 holds bytes 4 and 5, 0x04 holds bytes 2 and 3, and 0x08 holds bytes 0 and 1. In each register the lower-numbered byte sits in bits 15:8. Byte 0 is the first byte on the wire and is `daIn[47:40]`.
- R4: The broadcast address FF:FF:FF:FF:FF:FF is always accepted, whatever the configuration.
- R5: The flow-control address 01:80:C2:00:00:01 is always accepted. It is formed from the three fixed slot values 0x0180, 0xC200 and 0x0001, and needs no programming.
- R6: When hash enable is set, a multicast address (bit 0 of byte 0 is set) is accepted exactly when its indexed hash bit is 1. The index is the top 8 bits of the CRC described above: bits 7:4 select the word and bits 3:0 select the bit.
- R7: When hash enable is clear, the hash table has no effect, and a multicast address whose bit is set is rejected unless another rule admits it.
- R8: When the promiscuous bit is set, every address is accepted.
- R9: Unicast addresses are never looked up in the hash table. With every hash bit set, a unicast address that is not the station address is still rejected.
- R10: A write to an offset that maps to no register, including any offset not aligned to 4 bytes, changes nothing.
- R11: Hash word w is written at offset 0x40 + 4·w, for w from 0 to 15. With all sixteen words at 0xFFFF and hashing enabled, every multicast address is accepted.
- R12: The configuration word is at offset 0x80. Bit 0 is promiscuous and bit 1 is hash enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Byte offset of the write |
| regWdata | input | 16 | Write data |
| daValid | input | 1 | Destination address present this cycle |
| daIn | input | 48 | Destination address, byte 0 in bits 47:40 |
| decValid | output | 1 | Decision valid pulse |
| accept | output | 1 | Accept (1) or reject (0) for the last decision |

## Verification
The bench targets the points where a small slip silently changes which frames are kept.

- **Station byte order.** A design that swapped the bytes in a station register would reject its own address.
- **CRC form.** A design that shifted bits most significant first, inverted the result, or swapped the word and bit fields would index the wrong hash bit. The bench's own CRC model then disagrees with the accept bit on random multicasts.
- **Multicast test.** Filling the table with ones while sending unicast addresses catches a design that hashes unicast addresses too.
- **Fixed addresses, unused offsets and timing.** Broadcast and the flow-control address are sent with every rule off. Writes to unaligned and unmapped offsets must leave the accept results unchanged. A design with a pipeline one stage short or long would raise `decValid` in the wrong cycle.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  localparam int MAC_W      = 48;
  localparam int WORD_W     = 16;
  localparam int HASH_WORDS = 16;
  localparam int STA_REGS   = 3;
  localparam int HSEL_W     = $clog2(HASH_WORDS);
  localparam int BSEL_W     = $clog2(WORD_W);
  localparam int IDX_W      = HSEL_W + BSEL_W;

  // fixed flow-control address slots (bytes 0,1 / 2,3 / 4,5)
  localparam logic [WORD_W-1:0] CTRL_SLOT_HI  = 16'h0180;
  localparam logic [WORD_W-1:0] CTRL_SLOT_MID = 16'hC200;
  localparam logic [WORD_W-1:0] CTRL_SLOT_LO  = 16'h0001;
  localparam logic [MAC_W-1:0]  CTRL_ADDR     = {CTRL_SLOT_HI, CTRL_SLOT_MID, CTRL_SLOT_LO};

  typedef struct packed {
    logic [STA_REGS-1:0] staWe;
    logic                hashWe;
    logic [HSEL_W-1:0]   hashSel;
    logic                cfgWe;
    logic                loadDa;
    logic                evalDa;
  } strobe_t;
endpackage

// File: rtl/rxaf_ctrl.sv
module rxaf_ctrl
  import rxaf_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int STA_BASE  = 'h00,
  parameter int HASH_BASE = 'h40,
  parameter int CFG_OFF   = 'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              daValid,
  output strobe_t           str,
  output logic              decValid
);
  localparam logic [31:0] STA_SPAN  = 32'(4 * STA_REGS);
  localparam logic [31:0] HASH_SPAN = 32'(4 * HASH_WORDS);

  logic [31:0] staOff;
  logic [31:0] hashOff;
  logic        aligned;
  logic        staHit;
  logic        hashHit;
  logic        cfgHit;
  logic        s1Valid;

  always_comb begin
    staOff  = 32'(regAddr) - 32'(STA_BASE);
    hashOff = 32'(regAddr) - 32'(HASH_BASE);
    aligned = (regAddr[1:0] == 2'b00);
    staHit  = aligned && (staOff < STA_SPAN);
    hashHit = aligned && (hashOff < HASH_SPAN);
    cfgHit  = (32'(regAddr) == 32'(CFG_OFF));
  end

  generate
    for (genvar i = 0; i < STA_REGS; i++) begin : g_staWe
      assign str.staWe[i] = regWe && staHit && (staOff[31:2] == 30'(i));
    end
  endgenerate

  assign str.hashWe  = regWe && hashHit;
  assign str.hashSel = hashHit ? hashOff[HSEL_W+1:2] : '0;
  assign str.cfgWe   = regWe && cfgHit;
  assign str.loadDa  = daValid;
  assign str.evalDa  = s1Valid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      decValid <= 1'b0;
    end else begin
      s1Valid  <= daValid;
      decValid <= s1Valid;
    end
  end

  AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    daValid |-> ##2 decValid);  // R2
  AST_NO_SPURIOUS_DEC: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> $past(daValid, 2));  // R2
  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({str.staWe, str.hashWe, str.cfgWe}));  // R10
  AST_UNALIGNED_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr[1:0] != 2'b00) |-> ($countones({str.staWe, str.hashWe, str.cfgWe}) == 0));  // R10
endmodule

// File: rtl/rxaf_dp.sv
module rxaf_dp
  import rxaf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           str,
  input  logic [WORD_W-1:0] wdata,
  input  logic [MAC_W-1:0]  daIn,
  output logic              accept
);
  logic [WORD_W-1:0] staReg  [STA_REGS];
  logic [WORD_W-1:0] hashReg [HASH_WORDS];
  logic              cfgPromisc;
  logic              cfgHashEn;
  logic [MAC_W-1:0]  s1Addr;

  logic [IDX_W-1:0]  hashIdx;
  logic [HSEL_W-1:0] wordSel;
  logic [BSEL_W-1:0] bitSel;
  logic [MAC_W-1:0]  staAddr;
  logic isMcast, isBcast, staMatch, ctrlMatch, hashHit, acceptNext;

  // reflected CRC-32 over 6 bytes, LSB first, seed all ones, no final invert
  function automatic logic [IDX_W-1:0] hashIndex(input logic [MAC_W-1:0] a);
    logic [31:0] c;
    logic        fb;
    c = '1;
    for (int b = 0; b < MAC_W / 8; b++) begin
      for (int k = 0; k < 8; k++) begin
        fb = c[0] ^ a[MAC_W - 8 - 8*b + k];
        c  = {1'b0, c[31:1]} ^ (fb ? 32'hEDB88320 : 32'h0);
      end
    end
    return c[31 -: IDX_W];
  endfunction

  always_comb begin
    staAddr = '0;
    for (int i = 0; i < STA_REGS; i++) staAddr[WORD_W*i +: WORD_W] = staReg[i];
    hashIdx    = hashIndex(s1Addr);
    wordSel    = hashIdx[IDX_W-1 -: HSEL_W];
    bitSel     = hashIdx[BSEL_W-1:0];
    isMcast    = s1Addr[MAC_W-8];
    isBcast    = &s1Addr;
    staMatch   = (s1Addr == staAddr);
    ctrlMatch  = (s1Addr == CTRL_ADDR);
    hashHit    = hashReg[wordSel][bitSel];
    acceptNext = cfgPromisc || isBcast || staMatch || ctrlMatch ||
                 (isMcast && cfgHashEn && hashHit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STA_REGS; i++) staReg[i] <= '0;
      for (int i = 0; i < HASH_WORDS; i++) hashReg[i] <= '0;
      cfgPromisc <= 1'b0;
      cfgHashEn  <= 1'b0;
      s1Addr     <= '0;
      accept     <= 1'b0;
    end else begin
      for (int i = 0; i < STA_REGS; i++)
        if (str.staWe[i]) staReg[i] <= wdata;
      if (str.hashWe) hashReg[str.hashSel] <= wdata;
      if (str.cfgWe) begin
        cfgPromisc <= wdata[0];
        cfgHashEn  <= wdata[1];
      end
      if (str.loadDa) s1Addr <= daIn;
      if (str.evalDa) accept <= acceptNext;
    end
  end

  AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (str.evalDa && cfgPromisc) |=> accept);  // R8
  AST_BCAST_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (str.evalDa && s1Addr == '1) |=> accept);  // R4
  AST_CTRL_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (str.evalDa && s1Addr == CTRL_ADDR) |=> accept);  // R5
  AST_ACCEPT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !str.evalDa |=> $stable(accept));  // R2
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxaf_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int STA_BASE  = 'h00,
  parameter int HASH_BASE = 'h40,
  parameter int CFG_OFF   = 'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [15:0]       regWdata,
  input  logic              daValid,
  input  logic [47:0]       daIn,
  output logic              decValid,
  output logic              accept
);
  strobe_t str;

  rxaf_ctrl #(
    .ADDR_W(ADDR_W), .STA_BASE(STA_BASE), .HASH_BASE(HASH_BASE), .CFG_OFF(CFG_OFF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .daValid(daValid), .str(str), .decValid(decValid)
  );

  rxaf_dp u_dp (
    .clk(clk), .rstN(rstN), .str(str), .wdata(regWdata),
    .daIn(daIn), .accept(accept)
  );
endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic        daValid = 1'b0;
  logic [47:0] daIn = '0;
  logic        decValid;
  logic        accept;

  int checks = 0;
  int errors = 0;

  bit    expQ[$];
  string tagQ[$];

  logic [47:0] mSta = '0;
  logic [15:0] mHash [16];
  bit          mPromisc = 0;
  bit          mHashEn = 0;

  always #10 clk = ~clk;  // 50 MHz

  rx_addr_filter u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .daValid(daValid), .daIn(daIn), .decValid(decValid), .accept(accept)
  );

  function automatic logic [7:0] refIdx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    logic [7:0]  by;
    for (int b = 0; b < 6; b++) begin
      by = a[47 - 8*b -: 8];
      for (int k = 0; k < 8; k++) begin
        if ((c[0] ^ by[k]) == 1'b1) c = (c >> 1) ^ 32'hEDB88320;
        else c = c >> 1;
      end
    end
    return c[31:24];
  endfunction

  function automatic bit refAccept(input logic [47:0] a);
    logic [7:0] ix = refIdx(a);
    if (mPromisc) return 1;
    if (a == 48'hFFFFFFFFFFFF) return 1;
    if (a == 48'h0180C2000001) return 1;
    if (a == mSta) return 1;
    if (a[40] && mHashEn && mHash[ix[7:4]][ix[3:0]]) return 1;
    return 0;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    drain();
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
    if (a == 8'h00) mSta[15:0] = d;
    else if (a == 8'h04) mSta[31:16] = d;
    else if (a == 8'h08) mSta[47:32] = d;
    else if (a == 8'h80) begin mPromisc = d[0]; mHashEn = d[1]; end
    else if (a >= 8'h40 && a < 8'h80 && a[1:0] == 2'b00) mHash[a[5:2]] = d;
  endtask

  task automatic send(input logic [47:0] a, input string tag);
    expQ.push_back(refAccept(a));
    tagQ.push_back(tag);
    daValid = 1'b1; daIn = a;
    @(negedge clk);
    daValid = 1'b0;
  endtask

  task automatic sendExp(input logic [47:0] a, input bit exp, input string tag);
    checks++;
    if (refAccept(a) != exp) begin
      errors++;
      $display("FAIL %s model got %0b exp %0b", tag, refAccept(a), exp);
    end
    send(a, tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && decValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R2 spurious decValid got 1 exp 0");
      end else begin
        automatic bit    e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        if (accept !== e) begin
          errors++;
          $display("FAIL %s accept got %0b exp %0b", t, accept, e);
        end
      end
    end
  end

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog got timeout exp done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] mc;
    logic [7:0]  ix;
    for (int i = 0; i < 16; i++) mHash[i] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 decValid after reset", decValid, 0);
    sendExp(48'h021122334455, 0, "R1 unicast after reset");
    sendExp(48'h01005E000001, 0, "R1 multicast after reset");
    sendExp(48'hFFFFFFFFFFFF, 1, "R4 broadcast, all off");

    // R2 explicit latency
    drain();
    daValid = 1'b1; daIn = 48'hFFFFFFFFFFFF;
    expQ.push_back(1); tagQ.push_back("R2 latency");
    @(negedge clk); daValid = 1'b0;
    check("R2 no decValid after one edge", decValid, 0);
    @(negedge clk);
    check("R2 decValid after two edges", decValid, 1);
    @(negedge clk);
    check("R2 single pulse", decValid, 0);

    // R3 station address
    wr(8'h00, 16'h4455); wr(8'h04, 16'h2233); wr(8'h08, 16'h0211);
    sendExp(48'h021122334455, 1, "R3 station match");
    sendExp(48'h021122334454, 0, "R3 station near miss");
    sendExp(48'h554433221102, 0, "R3 byte-reversed station");

    sendExp(48'h0180C2000001, 1, "R5 control address");
    sendExp(48'h0180C2000002, 0, "R5 control near miss");

    // R6 hash hit on one bit
    mc = 48'h01005E000001;
    ix = refIdx(mc);
    wr(8'h80, 16'h0002);
    check("R12 hash enable written", 32'(mHashEn), 1);
    wr(8'h40 + {2'b00, ix[7:4], 2'b00}, 16'(1) << ix[3:0]);
    sendExp(mc, 1, "R6 multicast hash hit");
    for (int i = 2; i < 10; i++) send(48'h01005E000000 | 48'(i), "R6 multicast sweep");
    sendExp(48'h02005E000001, 0, "R9 unicast with same bits");

    // R7 hash disabled
    wr(8'h80, 16'h0000);
    sendExp(mc, 0, "R7 hash disabled");

    // R11 all ones
    for (int w = 0; w < 16; w++) wr(8'h40 + 8'(4*w), 16'hFFFF);
    wr(8'h80, 16'h0002);
    for (int i = 0; i < 8; i++)
      sendExp({8'h01 | 8'($urandom) , 40'($urandom) << 8 | 40'(i)}, 1, "R11 all-ones multicast");
    sendExp(48'h0A0B0C0D0E0F, 0, "R9 unicast ignores full hash");

    // R10 ignored writes
    for (int w = 0; w < 16; w++) wr(8'h40 + 8'(4*w), 16'h0000);
    wr(8'h41, 16'hFFFF); wr(8'h7E, 16'hFFFF); wr(8'h0C, 16'h1234);
    wr(8'h02, 16'hBEEF); wr(8'h84, 16'h0001); wr(8'h81, 16'h0001);
    sendExp(mc, 0, "R10 unaligned hash write ignored");
    sendExp(48'h021122334455, 1, "R10 station intact");
    sendExp(48'h0A0B0C0D0E0F, 0, "R10 promisc not set");

    // R8 promiscuous
    wr(8'h80, 16'h0001);
    sendExp(48'h0A0B0C0D0E0F, 1, "R8 promiscuous unicast");
    sendExp(mc, 1, "R8 promiscuous multicast");

    // back-to-back random stream with random hash contents
    wr(8'h80, 16'h0002);
    for (int w = 0; w < 16; w++) wr(8'h40 + 8'(4*w), 16'($urandom));
    drain();
    for (int i = 0; i < 40; i++) send({16'($urandom), 32'($urandom)}, "R6 back-to-back random");
    for (int i = 0; i < 20; i++) send({16'($urandom) | 16'h0100, 32'($urandom)}, "R6 random multicast");
    drain();
    check("R2 all results delivered", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule